// File: doc/BRIEF.md
# Interpolating Pulse-Width Digitiser

This block turns one pulse measurement into a width expressed in delay-line tap units. It combines a coarse count of gated reference-clock periods with two fine readings taken from a tapped delay line. At the leading event and at the trailing event, the delay line's state is latched as a thermometer vector. Each vector is turned into a tap index by an encoder that ignores isolated bubbles. The coarse count is then scaled by a calibrated number of taps per clock period, and the two fine indices are folded in.

The taps-per-period scale is not fixed. In calibrate mode, a capture whose trailing vector spans exactly one reference period is presented to the block. If the encoded index lies in a plausible window, it replaces the stored scale. If it does not, the reading is thrown away and the earlier scale is kept. Each measurement or calibration capture produces a one-cycle strobe two cycles after it is presented.

Top module: `tdc_interp`

## Requirements
- R1: While reset is held, and in the first cycle after it, `res_valid`, `res_bad`, `cal_done` and `cal_ok` are 0, `width_taps` is 0 and `cal_taps` is 25.
- R2: A capture presented in cycle k (`capture_valid`=1 at the rising edge that ends cycle k) raises exactly one strobe, one cycle wide, in cycle k+2. A measure capture (`mode_cal`=0) raises `res_valid`. A calibrate capture (`mode_cal`=1) raises `cal_done` and never `res_valid`.
- R3: A thermometer vector fills from bit 0 upward. Its fine index is p+1, where p is the highest bit position (p ≥ 1) at which bits p and p-1 are both 1. A vector with no such pair has index 0. An isolated 1 above the true edge, or an isolated 0 below it, therefore does not change the index.
- R4: For a valid measurement, `width_taps` = coarse × C + S − P. Here C is the stored `cal_taps`, S is the leading-event index and P is the trailing-event index.
- R5: If either captured vector of a measurement is all ones or all zeros, `res_bad`=1 and `width_taps`=0.
- R6: Before it is combined, a fine index larger than C is replaced by C. This handles an edge that lands on the coarse clock boundary.
- R7: A measurement whose combined value would be negative reports `width_taps`=0 with `res_bad`=0.
- R8: A calibrate capture is accepted when its trailing vector is neither all ones nor all zeros and its index lies within 20 to 40 inclusive. On acceptance, `cal_taps` takes the index and `cal_ok`=1 alongside `cal_done`. The leading vector and the coarse count are ignored in this mode.
- R9: A rejected calibrate capture gives `cal_done`=1 and `cal_ok`=0, and leaves `cal_taps` unchanged.
- R10: A measurement whose result strobe comes after an accepted calibration's strobe uses the new scale. This holds even when the two captures are presented back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cal | input | 1 | 1 = calibrate capture, 0 = measure capture |
| capture_valid | input | 1 | Captured vectors and coarse count are valid this cycle |
| coarse_cnt | input | 16 | Whole reference periods counted while the pulse was high |
| start_code | input | 40 | Delay-line state latched at the leading event |
| stop_code | input | 40 | Delay-line state latched at the trailing event |
| res_valid | output | 1 | Measurement result strobe |
| res_bad | output | 1 | Measurement had a saturated or empty vector |
| width_taps | output | 23 | Pulse width in tap units |
| cal_done | output | 1 | Calibration capture processed |
| cal_ok | output | 1 | Calibration capture accepted |
| cal_taps | output | 6 | Stored taps-per-period scale |

## Verification
The assertions assume that `mode_cal` is only meaningful when `capture_valid` is high. They also assume that the thermometer vectors arrive already captured and stable in the cycle they are presented, with no handshake back to the source. The stimulus drives every input half a cycle away from the active edge and holds each capture for exactly one cycle. It builds each vector from a tap count, then adds bubbles or saturation on purpose, so that every reading the encoder sees is one the bench model can predict. Calibration values are kept within the 6-bit index range, so the checks on the scale's window and on its stability are the only rules limiting `cal_taps`.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int TAPS      = 40;
    localparam int CNT_W     = 16;
    localparam int CAL_MIN   = 20;
    localparam int CAL_MAX   = 40;
    localparam int CAL_RESET = 25;
    localparam int IDX_W     = $clog2(TAPS + 1);
    localparam int WID_W     = CNT_W + IDX_W + 1;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAPS-1:0]  code_t;

    typedef struct packed {
        logic              v;
        logic              cal;
        logic              bad;
        logic [CNT_W-1:0]  coarse;
        idx_t              s_idx;
        idx_t              p_idx;
    } stage1_t;

    // highest position with two adjacent ones, plus one; 0 when none
    function automatic idx_t therm_index(input code_t code);
        idx_t r;
        r = '0;
        for (int p = 1; p < TAPS; p++) begin
            if (code[p] && code[p-1]) r = idx_t'(p + 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/tdc_thermo_enc.sv
module tdc_thermo_enc
    import tdc_pkg::*;
(
    input  code_t code,
    output idx_t  idx,
    output logic  bad
);
    always_comb begin
        idx = therm_index(code);
        bad = (code == '0) || (code == '1);
    end
endmodule

// File: rtl/tdc_cal_reg.sv
module tdc_cal_reg
    import tdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  idx_t cand,
    input  logic cand_bad,
    output idx_t cal_q,
    output logic done,
    output logic ok
);
    logic accept;

    always_comb begin
        accept = !cand_bad && (int'(cand) >= CAL_MIN) && (int'(cand) <= CAL_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= idx_t'(CAL_RESET);
            done  <= 1'b0;
            ok    <= 1'b0;
        end else begin
            done <= upd;
            ok   <= upd && accept;
            if (upd && accept) cal_q <= cand;
        end
    end
endmodule

// File: rtl/tdc_combine.sv
module tdc_combine
    import tdc_pkg::*;
(
    input  logic [CNT_W-1:0] coarse,
    input  idx_t             s_idx,
    input  idx_t             p_idx,
    input  idx_t             cal,
    input  logic             bad,
    output logic [WID_W-1:0] width
);
    localparam int SW = WID_W + 1;
    idx_t          s_c, p_c;
    logic [SW-1:0] tot;

    always_comb begin
        s_c = (s_idx > cal) ? cal : s_idx;
        p_c = (p_idx > cal) ? cal : p_idx;
        tot = SW'(coarse) * SW'(cal) + SW'(s_c) - SW'(p_c);
        if (bad || tot[SW-1]) width = '0;
        else                  width = tot[WID_W-1:0];
    end
endmodule

// File: rtl/tdc_interp.sv
module tdc_interp
    import tdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_cal,
    input  logic             capture_valid,
    input  logic [CNT_W-1:0] coarse_cnt,
    input  logic [TAPS-1:0]  start_code,
    input  logic [TAPS-1:0]  stop_code,
    output logic             res_valid,
    output logic             res_bad,
    output logic [WID_W-1:0] width_taps,
    output logic             cal_done,
    output logic             cal_ok,
    output logic [IDX_W-1:0] cal_taps
);
    code_t   codes [2];
    idx_t    idx   [2];
    logic    bad   [2];
    stage1_t s1;
    logic [WID_W-1:0] w_next;

    assign codes[0] = start_code;
    assign codes[1] = stop_code;

    for (genvar g = 0; g < 2; g++) begin : g_enc
        tdc_thermo_enc enc_i (.code(codes[g]), .idx(idx[g]), .bad(bad[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.v      <= capture_valid;
            s1.cal    <= mode_cal;
            s1.bad    <= mode_cal ? bad[1] : (bad[0] || bad[1]);
            s1.coarse <= coarse_cnt;
            s1.s_idx  <= idx[0];
            s1.p_idx  <= idx[1];
        end
    end

    tdc_cal_reg cal_i (
        .clk(clk), .rst(rst),
        .upd(s1.v && s1.cal), .cand(s1.p_idx), .cand_bad(s1.bad),
        .cal_q(cal_taps), .done(cal_done), .ok(cal_ok)
    );

    tdc_combine comb_i (
        .coarse(s1.coarse), .s_idx(s1.s_idx), .p_idx(s1.p_idx),
        .cal(cal_taps), .bad(s1.bad), .width(w_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_bad    <= 1'b0;
            width_taps <= '0;
        end else begin
            res_valid <= s1.v && !s1.cal;
            if (s1.v && !s1.cal) begin
                res_bad    <= s1.bad;
                width_taps <= w_next;
            end
        end
    end
endmodule

// File: rtl/tdc_interp_chk.sv
module tdc_interp_chk
    import tdc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mode_cal,
    input logic             capture_valid,
    input logic             res_valid,
    input logic             res_bad,
    input logic [WID_W-1:0] width_taps,
    input logic             cal_done,
    input logic             cal_ok,
    input logic [IDX_W-1:0] cal_taps
);
    AST_RES_LATENCY: assert property (@(posedge clk) disable iff (rst)
        capture_valid && !mode_cal |=> ##1 res_valid); // R2
    AST_CAL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        capture_valid && mode_cal |=> ##1 cal_done); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(capture_valid, 2) && !$past(mode_cal, 2)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && cal_done)); // R2
    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_bad |-> width_taps == '0); // R5
    AST_CAL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        int'(cal_taps) >= CAL_MIN && int'(cal_taps) <= CAL_MAX); // R8
    AST_CAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cal_done && cal_ok) |-> $stable(cal_taps)); // R9
    AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        cal_ok |-> cal_done); // R8
endmodule

bind tdc_interp tdc_interp_chk chk_i (.*);

// File: tb/tdc_interp_tb_top.sv
module tdc_interp_tb_top;
    import tdc_pkg::*;

    typedef struct {
        bit      is_cal;
        longint  width;
        bit      bad;
        bit      ok;
        longint  cal;
        longint  cyc;
    } exp_t;

    logic clk = 0, rst = 1;
    logic mode_cal = 0, capture_valid = 0;
    logic [CNT_W-1:0] coarse_cnt = '0;
    logic [TAPS-1:0]  start_code = '0, stop_code = '0;
    logic res_valid, res_bad, cal_done, cal_ok;
    logic [WID_W-1:0] width_taps;
    logic [IDX_W-1:0] cal_taps;

    int checks = 0, fails = 0;
    longint cyc = 0;
    longint model_cal = 25;
    exp_t q[$];
    bit done_run = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tdc_interp dut_i (.*);

    task automatic chk(input bit good, input string tag, input longint act, input longint exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [TAPS-1:0] therm(input int n);
        logic [TAPS-1:0] t;
        t = '0;
        for (int i = 0; i < n; i++) t[i] = 1'b1;
        return t;
    endfunction

    function automatic longint enc(input logic [TAPS-1:0] c);
        for (int p = TAPS - 1; p >= 1; p--)
            if (c[p] && c[p-1]) return p + 1;
        return 0;
    endfunction

    function automatic bit sat(input logic [TAPS-1:0] c);
        return (c == '0) || (c == '1);
    endfunction

    task automatic issue(input bit cal, input longint coarse,
                         input logic [TAPS-1:0] sc, input logic [TAPS-1:0] pc);
        exp_t e;
        longint s, p, w;
        e.is_cal = cal; e.cyc = cyc; e.width = 0; e.bad = 0; e.ok = 0;
        if (cal) begin
            p = enc(pc);
            e.ok = !sat(pc) && p >= 20 && p <= 40;
            if (e.ok) model_cal = p;
        end else begin
            e.bad = sat(sc) || sat(pc);
            s = enc(sc); p = enc(pc);
            if (s > model_cal) s = model_cal;
            if (p > model_cal) p = model_cal;
            w = coarse * model_cal + s - p;
            e.width = (e.bad || w < 0) ? 0 : w;
        end
        e.cal = model_cal;
        q.push_back(e);
        mode_cal = cal; capture_valid = 1;
        coarse_cnt = CNT_W'(coarse); start_code = sc; stop_code = pc;
        @(negedge clk);
        capture_valid = 0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && (res_valid || cal_done)) begin
            exp_t e;
            if (q.size() == 0) begin
                chk(0, "R2 unexpected strobe", 1, 0);
            end else begin
                e = q.pop_front();
                chk(cyc - e.cyc == 2, "R2 latency", cyc - e.cyc, 2);
                if (e.is_cal) begin
                    chk(cal_done && !res_valid, "R2 cal strobe kind", res_valid, 0);
                    chk(cal_ok == e.ok, "R8/R9 cal_ok", cal_ok, e.ok);
                    chk(cal_taps == e.cal, "R8/R9 cal_taps", cal_taps, e.cal);
                end else begin
                    chk(res_valid && !cal_done, "R2 res strobe kind", cal_done, 0);
                    chk(res_bad == e.bad, "R5 res_bad", res_bad, e.bad);
                    chk(width_taps == e.width, "R4/R6/R7/R10 width", width_taps, e.width);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [TAPS-1:0] b;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!res_valid && !cal_done && !cal_ok && !res_bad, "R1 strobes", res_valid, 0);
        chk(cal_taps == 25, "R1 cal_taps", cal_taps, 25);
        rst = 0;
        @(negedge clk);
        chk(width_taps == 0 && !res_valid, "R1 width after reset", width_taps, 0);

        // R4 plain
        issue(0, 10, therm(7), therm(3));
        // R3 bubbles: hole below edge, lone one above edge
        b = therm(12); b[5] = 1'b0;
        issue(0, 2, b, therm(3) | (40'd1 << 30));
        // R6 boundary clamp with scale 25
        issue(0, 1, therm(30), therm(2));
        // R7 negative result
        issue(0, 0, therm(2), therm(9));
        // R5 saturated / empty
        issue(0, 5, '1, therm(4));
        issue(0, 5, therm(4), '0);
        repeat (3) @(negedge clk);
        // R8 accept, start ignored, then R10 back to back
        issue(1, 999, '1, therm(32));
        issue(0, 3, therm(10), therm(4));
        // R9 rejects: too small, saturated, just below window
        issue(1, 0, '0, therm(15));
        issue(1, 0, '0, '1);
        issue(1, 0, '0, therm(19));
        issue(0, 4, therm(35), therm(1));
        // R8 lower edge of window
        issue(1, 0, '0, therm(20));
        issue(0, 7, therm(21), therm(20));
        // sweep
        for (int i = 0; i < 40; i++) begin
            issue(0, (i * 37) % 500, therm((i % 38) + 2), therm(((i * 7) % 38) + 2));
            if (i % 3 == 0) @(negedge clk);
        end
        issue(1, 0, '0, therm(39));
        for (int i = 0; i < 10; i++) issue(0, i * 11, therm(i + 2), therm(39 - i));
        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R2 missing strobes", q.size(), 0);
        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule